// File: doc/BRIEF.md
# Packed Ternary Dot Product Engine

The engine forms the signed dot product of two balanced-ternary vectors held in packed form. Every trit takes two bits and a 64-bit word carries 32 of them. Software or an upstream fetch unit pulses a start strobe together with the trit length of each vector. The engine then accepts the two vectors as a stream of paired words, one pair per clock, under a valid/ready handshake.

No multiplier is used. Each incoming word is split into a one-bit-per-lane positive plane and negative plane, and unused codes are cleared. Four population counts of plane intersections give the number of matching-sign and opposite-sign lanes. Their difference is added to a signed accumulator. The lanes past the end of the vector in the final partial word are masked off. One cycle after the last word is taken, a done pulse marks the result, and the result stays on the output until the next start.

Top module: `tdot_engine`

## Requirements
- R1: A trit code is read as 01 = +1, 10 = -1, 00 = 0, and the unused code 11 counts as 0 in both operands (it adds nothing to the total).
- R2: Trit i sits in bits 2(i mod 32) (low bit) and 2(i mod 32)+1 (high bit) of the (i div 32)-th word pair accepted after start, counting from zero.
- R3: Every accepted word pair changes the result by (lanes where both are +1 or both are -1) minus (lanes with one +1 and one -1), so each step lies within ±32.
- R4: The effective length n is the smaller of the two lengths, and exactly ceil(n/32) word pairs are accepted for a job.
- R5: In the final word, only lanes below n mod 32 count. When n mod 32 is 0, all 32 lanes of the final word count.
- R6: When n is 0, done pulses one cycle after start, the result is 0, and wr_ready_o stays low.
- R7: done_o is high for exactly one cycle, the cycle after the last word pair is accepted. dot_o holds the final value until the next accepted start.
- R8: A start accepted while idle clears dot_o to 0 in the following cycle. A start while a job is running is ignored and has no effect on the length, the count or the result.
- R9: dot_o is a 32-bit two's-complement signed value, and results are exact up to the full length range (65535 trits).
- R10: wr_ready_o is high exactly while the engine still expects word pairs. Cycles with wr_valid_i low consume nothing and add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new job (taken only while idle) |
| len_a_i | input | LEN_W | Trit length of vector A |
| len_b_i | input | LEN_W | Trit length of vector B |
| wr_valid_i | input | 1 | A word pair is present |
| wr_ready_o | output | 1 | Engine accepts a word pair this cycle |
| word_a_i | input | WORD_W | Packed word of vector A |
| word_b_i | input | WORD_W | Packed word of vector B |
| done_o | output | 1 | One-cycle pulse: result complete |
| dot_o | output | ACC_W | Signed dot product (running, final at done) |

## Verification
The main function is driven with uniform words (all +1 against +1, +1 against -1), with words made only of code 11, and with a hand-built word that mixes all four codes. Together these separate a correct sign rule from a swapped plane or an unused code that leaks through. A single nonzero lane in the second word checks lane and word placement. Partial final words with nonzero junk past the end, and an exact multiple of 32, check the tail mask. Unequal and zero lengths check the length selection. Random words with valid gaps and a stray start in mid-stream check the handshake and the ignore rule. A maximum-length run checks the width of the result.

// File: rtl/tdot_pkg.sv
package tdot_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  // intersection slots used by the scorer
  localparam int ISECT_N = 4;
  localparam int IX_PP   = 0;
  localparam int IX_NN   = 1;
  localparam int IX_PN   = 2;
  localparam int IX_NP   = 3;

endpackage

// File: rtl/tdot_popcnt.sv
module tdot_popcnt #(
  parameter int IN_W = 32
) (
  input  logic [IN_W-1:0]            bits_i,
  output logic [$clog2(IN_W+1)-1:0]  cnt_o
);
  localparam int CNT_W = $clog2(IN_W + 1);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < IN_W; i++) begin
      cnt_o = cnt_o + CNT_W'(bits_i[i]);
    end
  end
endmodule

// File: rtl/tdot_split.sv
module tdot_split #(
  parameter int LANES = 32
) (
  input  logic [2*LANES-1:0] word_i,
  input  logic [LANES-1:0]   keep_i,
  output logic [LANES-1:0]   pos_o,
  output logic [LANES-1:0]   neg_o
);
  // low bit of a lane marks +1, high bit marks -1; both set means zero
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic lo, hi;
    assign lo = word_i[2*j];
    assign hi = word_i[2*j+1];
    assign pos_o[j] = keep_i[j] & lo & ~hi;
    assign neg_o[j] = keep_i[j] & hi & ~lo;
  end
endmodule

// File: rtl/tdot_tail_mask.sv
module tdot_tail_mask #(
  parameter int LANES = 32
) (
  input  logic                     last_i,
  input  logic [$clog2(LANES)-1:0] tail_i,
  output logic [LANES-1:0]         keep_o
);
  localparam int LANE_W = $clog2(LANES);

  logic full_word;
  assign full_word = ~last_i | (tail_i == '0);

  for (genvar j = 0; j < LANES; j++) begin : g_keep
    assign keep_o[j] = full_word | (LANE_W'(j) < tail_i);
  end
endmodule

// File: rtl/tdot_score.sv
module tdot_score
  import tdot_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [2*LANES-1:0]                 word_a_i,
  input  logic [2*LANES-1:0]                 word_b_i,
  input  logic [LANES-1:0]                   keep_i,
  output logic signed [$clog2(LANES+1)+1:0]  score_o
);
  localparam int CNT_W = $clog2(LANES + 1);

  logic [LANES-1:0] a_pos, a_neg, b_pos, b_neg;
  logic [LANES-1:0] isect [ISECT_N];
  logic [CNT_W-1:0] cnt   [ISECT_N];
  logic [CNT_W:0]   same_sum, opp_sum;

  tdot_split #(.LANES(LANES)) u_split_a (
    .word_i (word_a_i),
    .keep_i (keep_i),
    .pos_o  (a_pos),
    .neg_o  (a_neg)
  );

  tdot_split #(.LANES(LANES)) u_split_b (
    .word_i (word_b_i),
    .keep_i (keep_i),
    .pos_o  (b_pos),
    .neg_o  (b_neg)
  );

  assign isect[IX_PP] = a_pos & b_pos;
  assign isect[IX_NN] = a_neg & b_neg;
  assign isect[IX_PN] = a_pos & b_neg;
  assign isect[IX_NP] = a_neg & b_pos;

  for (genvar k = 0; k < ISECT_N; k++) begin : g_cnt
    tdot_popcnt #(.IN_W(LANES)) u_pc (
      .bits_i (isect[k]),
      .cnt_o  (cnt[k])
    );
  end

  always_comb begin
    same_sum = {1'b0, cnt[IX_PP]} + {1'b0, cnt[IX_NN]};
    opp_sum  = {1'b0, cnt[IX_PN]} + {1'b0, cnt[IX_NP]};
    score_o  = $signed({1'b0, same_sum}) - $signed({1'b0, opp_sum});
  end
endmodule

// File: rtl/tdot_seq.sv
module tdot_seq
  import tdot_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LANES = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [LEN_W-1:0]         len_a_i,
  input  logic [LEN_W-1:0]         len_b_i,
  input  logic                     wr_valid_i,
  output logic                     ready_o,
  output logic                     accept_o,
  output logic                     clear_o,
  output logic                     last_o,
  output logic [$clog2(LANES)-1:0] tail_o,
  output logic                     done_o
);
  localparam int LANE_W = $clog2(LANES);
  localparam int CNT_W  = LEN_W - LANE_W + 1;

  seq_state_e        state_q;
  logic [CNT_W-1:0]  left_q;
  logic [LANE_W-1:0] tail_q;
  logic              done_q;

  logic [LEN_W-1:0]  eff_len;
  logic [LEN_W:0]    round_up;
  logic [CNT_W-1:0]  n_words;
  logic              start_take;

  always_comb begin
    eff_len  = (len_a_i < len_b_i) ? len_a_i : len_b_i;
    round_up = {1'b0, eff_len} + (LEN_W+1)'(LANES - 1);
    n_words  = round_up[LEN_W:LANE_W];
  end

  assign start_take = start_i & (state_q == ST_IDLE);
  assign ready_o    = (state_q == ST_RUN);
  assign accept_o   = ready_o & wr_valid_i;
  assign clear_o    = start_take;
  assign last_o     = (left_q == CNT_W'(1));
  assign tail_o     = tail_q;
  assign done_o     = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      tail_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_take) begin
        tail_q <= eff_len[LANE_W-1:0];
        left_q <= n_words;
        if (eff_len == '0) begin
          done_q <= 1'b1;
        end else begin
          state_q <= ST_RUN;
        end
      end else if (accept_o) begin
        left_q <= left_q - CNT_W'(1);
        if (last_o) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdot_engine.sv
module tdot_engine #(
  parameter int WORD_W = 64,
  parameter int LEN_W  = 16,
  parameter int ACC_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [LEN_W-1:0]        len_a_i,
  input  logic [LEN_W-1:0]        len_b_i,
  input  logic                    wr_valid_i,
  output logic                    wr_ready_o,
  input  logic [WORD_W-1:0]       word_a_i,
  input  logic [WORD_W-1:0]       word_b_i,
  output logic                    done_o,
  output logic signed [ACC_W-1:0] dot_o
);
  localparam int LANES  = WORD_W / 2;
  localparam int LANE_W = $clog2(LANES);
  localparam int SC_W   = $clog2(LANES + 1) + 2;

  logic                    accept, clear, last;
  logic [LANE_W-1:0]       tail;
  logic [LANES-1:0]        keep;
  logic signed [SC_W-1:0]  score;
  logic signed [ACC_W-1:0] acc_q;

  tdot_seq #(.LEN_W(LEN_W), .LANES(LANES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .len_a_i    (len_a_i),
    .len_b_i    (len_b_i),
    .wr_valid_i (wr_valid_i),
    .ready_o    (wr_ready_o),
    .accept_o   (accept),
    .clear_o    (clear),
    .last_o     (last),
    .tail_o     (tail),
    .done_o     (done_o)
  );

  tdot_tail_mask #(.LANES(LANES)) u_mask (
    .last_i (last),
    .tail_i (tail),
    .keep_o (keep)
  );

  tdot_score #(.LANES(LANES)) u_score (
    .word_a_i (word_a_i),
    .word_b_i (word_b_i),
    .keep_i   (keep),
    .score_o  (score)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (clear) begin
      acc_q <= '0;
    end else if (accept) begin
      acc_q <= acc_q + {{(ACC_W-SC_W){score[SC_W-1]}}, score};
    end
  end

  assign dot_o = acc_q;
endmodule

// File: rtl/tdot_engine_chk.sv
module tdot_engine_chk #(
  parameter int LEN_W = 16,
  parameter int ACC_W = 32,
  parameter int LANES = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start_i,
  input logic [LEN_W-1:0]        len_a_i,
  input logic [LEN_W-1:0]        len_b_i,
  input logic                    wr_valid_i,
  input logic                    wr_ready_o,
  input logic                    done_o,
  input logic signed [ACC_W-1:0] dot_o
);
  logic signed [ACC_W-1:0] prev_q;
  logic signed [ACC_W-1:0] delta;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= dot_o;
  end
  assign delta = dot_o - prev_q;

  p_step_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_i && wr_ready_o) |=> (delta >= -LANES && delta <= LANES));

  p_busy_after_start_r4: assert property (@(posedge clk) disable iff (rst)
    (start_i && !wr_ready_o && len_a_i != '0 && len_b_i != '0) |=> (wr_ready_o && !done_o));

  p_zero_len_r6: assert property (@(posedge clk) disable iff (rst)
    (start_i && !wr_ready_o && (len_a_i == '0 || len_b_i == '0)) |=> (done_o && !wr_ready_o));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !wr_ready_o);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> !done_o);

  p_hold_result_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr_ready_o && !start_i) |=> $stable(dot_o));

  p_clear_on_start_r8: assert property (@(posedge clk) disable iff (rst)
    (start_i && !wr_ready_o) |=> (dot_o == '0));

  p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (rst)
    (start_i && wr_ready_o && !wr_valid_i) |=> (wr_ready_o && $stable(dot_o)));

  p_gap_no_change_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_ready_o && !wr_valid_i && !start_i) |=> (wr_ready_o && $stable(dot_o)));
endmodule

bind tdot_engine tdot_engine_chk #(
  .LEN_W (LEN_W),
  .ACC_W (ACC_W),
  .LANES (LANES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .len_a_i    (len_a_i),
  .len_b_i    (len_b_i),
  .wr_valid_i (wr_valid_i),
  .wr_ready_o (wr_ready_o),
  .done_o     (done_o),
  .dot_o      (dot_o)
);

// File: tb/tdot_engine_test.sv
module tdot_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 64;
  localparam int LEN_W      = 16;
  localparam int ACC_W      = 32;
  localparam int WDOG_LIMIT = 100000;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    start_i = 1'b0;
  logic [LEN_W-1:0]        len_a_i = '0;
  logic [LEN_W-1:0]        len_b_i = '0;
  logic                    wr_valid_i = 1'b0;
  logic                    wr_ready_o;
  logic [WORD_W-1:0]       word_a_i = '0;
  logic [WORD_W-1:0]       word_b_i = '0;
  logic                    done_o;
  logic signed [ACC_W-1:0] dot_o;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;

  logic [63:0] qa[$];
  logic [63:0] qb[$];

  tdot_engine #(.WORD_W(WORD_W), .LEN_W(LEN_W), .ACC_W(ACC_W)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .len_a_i(len_a_i), .len_b_i(len_b_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .word_a_i(word_a_i),
    .word_b_i(word_b_i), .done_o(done_o), .dot_o(dot_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int trit_val(logic [1:0] c);
    case (c)
      2'b01:   return 1;
      2'b10:   return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_score(logic [63:0] a, logic [63:0] b, int used);
    int s = 0;
    for (int j = 0; j < used; j++) s += trit_val(a[2*j +: 2]) * trit_val(b[2*j +: 2]);
    return s;
  endfunction

  function automatic int exp_dot(int la, int lb);
    int n = (la < lb) ? la : lb;
    int s = 0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] wa = qa[i/32];
      logic [63:0] wb = qb[i/32];
      s += trit_val(wa[(i%32)*2 +: 2]) * trit_val(wb[(i%32)*2 +: 2]);
    end
    return s;
  endfunction

  // cycle-level reference model
  bit m_busy = 0;
  bit m_done = 0;
  int m_left = 0;
  int m_tail = 0;
  int m_acc  = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_left = 0; m_tail = 0; m_acc = 0;
    end else begin : model_step
      bit nd;
      int n;
      nd = 0;
      if (!m_busy && start_i) begin
        n = (len_a_i < len_b_i) ? int'(len_a_i) : int'(len_b_i);
        m_acc = 0;
        if (n == 0) nd = 1;
        else begin
          m_busy = 1;
          m_left = (n + 31) / 32;
          m_tail = n % 32;
        end
      end else if (m_busy && wr_valid_i) begin
        m_acc += ref_score(word_a_i, word_b_i, (m_left == 1 && m_tail != 0) ? m_tail : 32);
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          nd = 1;
        end
      end
      m_done = nd;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R10 ready vs model", longint'(wr_ready_o), longint'(m_busy));
      chk("R7 done vs model", longint'(done_o), longint'(m_done));
      chk("R3 running result vs model", longint'(dot_o), longint'(m_acc));
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > WDOG_LIMIT) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc_cnt, WDOG_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic fill(int nw, logic [63:0] pa, logic [63:0] pb);
    qa.delete(); qb.delete();
    for (int i = 0; i < nw; i++) begin
      qa.push_back(pa);
      qb.push_back(pb);
    end
  endtask

  task automatic fill_rand(int nw);
    qa.delete(); qb.delete();
    for (int i = 0; i < nw; i++) begin
      qa.push_back({$urandom, $urandom});
      qb.push_back({$urandom, $urandom});
    end
  endtask

  // starts a job, feeds the words from qa/qb, checks done and hold
  task automatic run_job(string tag, int la, int lb, int gap_mod, int poke_at);
    int n, nw, w, cyc, exp;
    n   = (la < lb) ? la : lb;
    nw  = (n + 31) / 32;
    exp = exp_dot(la, lb);
    @(negedge clk);
    start_i = 1'b1; len_a_i = LEN_W'(la); len_b_i = LEN_W'(lb); wr_valid_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    if (n == 0) begin
      chk({"R6 done after zero length (", tag, ")"}, longint'(done_o), 1);
      chk({"R6 ready stays low (", tag, ")"}, longint'(wr_ready_o), 0);
      chk({"R6 zero result (", tag, ")"}, longint'(dot_o), 0);
      @(negedge clk);
      chk({"R6 ready still low (", tag, ")"}, longint'(wr_ready_o), 0);
      return;
    end
    chk({"R8 start clears result (", tag, ")"}, longint'(dot_o), 0);
    w = 0;
    cyc = 0;
    while (w < nw) begin
      if (gap_mod > 0 && (cyc % gap_mod) == gap_mod - 1) begin
        wr_valid_i = 1'b0;
      end else begin
        wr_valid_i = 1'b1;
        word_a_i = qa[w];
        word_b_i = qb[w];
      end
      start_i = (cyc == poke_at);
      if (start_i) begin
        len_a_i = LEN_W'(3);
        len_b_i = LEN_W'(3);
      end
      if (wr_valid_i && wr_ready_o) w++;
      cyc++;
      @(negedge clk);
    end
    wr_valid_i = 1'b0;
    start_i = 1'b0;
    chk({"R7 done after last word (", tag, ")"}, longint'(done_o), 1);
    chk({tag, " final result"}, longint'(dot_o), longint'(exp));
    @(negedge clk);
    chk({"R7 done is one cycle (", tag, ")"}, longint'(done_o), 0);
    chk({"R7 result held (", tag, ")"}, longint'(dot_o), longint'(exp));
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ready low after reset", longint'(wr_ready_o), 0);
    chk("R7 done low after reset", longint'(done_o), 0);
    chk("R7 result zero after reset", longint'(dot_o), 0);

    // all +1 against all +1: 64
    fill(2, 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555);
    run_job("R3 all plus", 64, 64, 0, -1);
    chk("R3 literal 64", longint'(dot_o), 64);

    // +1 against -1 over 40 trits, second word junk beyond lane 8: -40
    fill(2, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA);
    run_job("R9 R5 negative partial", 40, 40, 0, -1);
    chk("R9 literal -40", longint'(dot_o), -40);

    // code 11 everywhere in A: 0
    fill(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555);
    run_job("R1 unused code", 32, 32, 0, -1);
    chk("R1 literal 0", longint'(dot_o), 0);

    // mixed codes: lanes (01,01)=+1 (10,10)=+1 (11,10)=0 (00,10)=0 -> 2
    fill(1, 64'h39, 64'hA9);
    run_job("R1 mixed codes", 4, 4, 0, -1);
    chk("R1 literal 2", longint'(dot_o), 2);

    // trit 37 = word 1 lane 5: +1 against -1 -> -1
    fill(2, 64'h0, 64'h0);
    qa[1] = 64'h400;
    qb[1] = 64'h800;
    qa[0] = 64'h400;
    run_job("R2 lane position", 64, 64, 0, -1);
    chk("R2 literal -1", longint'(dot_o), -1);

    // unequal lengths: only 10 trits, one word
    fill(2, 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555);
    run_job("R4 min length", 10, 50, 0, -1);
    chk("R4 literal 10", longint'(dot_o), 10);

    // zero lengths
    run_job("R6 len a zero", 0, 7, 0, -1);
    run_job("R6 len b zero", 9, 0, 0, -1);

    // exact multiple of 32: full final word
    fill(1, 64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA);
    run_job("R5 full final word", 32, 32, 0, -1);
    chk("R5 literal 32", longint'(dot_o), 32);

    // random with valid gaps
    fill_rand(4);
    run_job("R10 gaps random", 100, 100, 3, -1);

    // stray start while busy
    fill_rand(3);
    run_job("R8 start while busy", 90, 95, 0, 1);

    // longer random run
    fill_rand(32);
    run_job("R3 long random", 1000, 1010, 5, -1);

    // maximum length
    fill(2048, 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555);
    run_job("R9 max length", 65535, 65535, 0, -1);
    chk("R9 literal 65535", longint'(dot_o), 65535);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule